// File: doc/BRIEF.md
# Set-Associative Hit/Miss Tag Directory

This block tracks which memory blocks a set-associative cache would be holding. It does so without storing any data. Each cycle it can accept one access address, which may be an instruction fetch or a load/store address. The block decides whether the containing block is resident, reports hit or miss one cycle later, and updates the replacement order of the indexed set. It also keeps saturating totals of hits and misses. A trace can therefore be streamed through it to measure the miss behaviour of a given geometry.

Each set is held as a list of block addresses, ordered newest first. The replacement policy works on that list in one of two ways. Under LRU, a referenced block moves to the head. Under FIFO, the order tracks load time only. In both policies a miss pushes the new block in at the head and drops the tail entry. The set count, block size, associativity, address width and counter width are all parameters. With one way, the block acts as a direct-mapped directory.

Top module: `assoc_tag_dir`

## Requirements
- R1: The low log2(BLOCK_BYTES) address bits are the block offset, and the next log2(SETS) bits select the set. A hit requires a valid way of that set whose stored block address (the address shifted right by log2(BLOCK_BYTES)) equals the incoming one. With the defaults, bits 4..0 are the offset and bits 8..5 select the set.
- R2: resp_valid_o is high exactly in the cycle after a cycle with req_valid_i high. In that cycle resp_hit_o is 1 for a hit and 0 for a miss.
- R3: While rst_ni is low, every way of every set becomes invalid, both counters read zero and resp_valid_o is low. Invalid ways never produce a hit.
- R4: In LRU mode, a hit moves the matching block to the head of its set and keeps the relative order of the others. A miss inserts the block at the head and evicts the tail, which is the least recently referenced block.
- R5: In FIFO mode, a hit leaves the set order unchanged. A miss inserts at the head and evicts the tail, so the block loaded earliest is the one lost.
- R6: With WAYS = 1, every miss replaces the single way of the indexed set. Two blocks that map to one set then miss on every alternating access.
- R7: An access in the cycle right after another access to the same set sees the order that the first access left.
- R8: hit_count_o and miss_count_o each rise by one per access of their kind, become visible together with that access's response, and hold at all ones instead of wrapping.
- R9: policy_fifo_i (0 = LRU, 1 = FIFO) is captured only on clock edges where req_valid_i is low. Changing the mode leaves the stored order of every set untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Access present this cycle |
| req_addr_i | input | ADDR_W | Access byte address |
| policy_fifo_i | input | 1 | Mode request: 0 LRU, 1 FIFO |
| resp_valid_o | output | 1 | Result strobe, one cycle after the access |
| resp_hit_o | output | 1 | 1 hit, 0 miss |
| hit_count_o | output | CNT_W | Saturating hit total |
| miss_count_o | output | CNT_W | Saturating miss total |

## Verification
A queue-based model of every set follows each access, and the bench compares both a four-way instance and a one-way instance against it on every cycle. Directed sequences cover several hazards:
- A filled LRU set that is hit and then missed, where a design that evicts the wrong end shows up as a later hit or miss in the wrong place.
- A FIFO hit that must not reorder the set, which would otherwise spare the oldest block.
- Back-to-back same-set accesses, which expose stale reads.
- Mode changes issued while accesses are in flight, which must be ignored.

A narrow-counter instance is driven past its maximum, which catches a counter that wraps to zero.

// File: rtl/tagdir_pkg.sv
package tagdir_pkg;
  typedef enum logic {
    POL_LRU  = 1'b0,
    POL_FIFO = 1'b1
  } repl_pol_e;
endpackage

// File: rtl/tagdir_split.sv
module tagdir_split #(
  parameter int ADDR_W      = 32,
  parameter int SETS        = 16,
  parameter int BLOCK_BYTES = 32,
  localparam int OFF_W      = $clog2(BLOCK_BYTES),
  localparam int IDX_W      = $clog2(SETS),
  localparam int BLK_W      = ADDR_W - OFF_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [IDX_W-1:0]  set_o,
  output logic [BLK_W-1:0]  blk_o
);
  assign blk_o = addr_i[ADDR_W-1:OFF_W];
  assign set_o = addr_i[OFF_W +: IDX_W];
endmodule

// File: rtl/tagdir_order.sv
// One set as a newest-first list; computes hit and the reordered list.
module tagdir_order
  import tagdir_pkg::*;
#(
  parameter int WAYS  = 4,
  parameter int BLK_W = 27
) (
  input  repl_pol_e                      pol_i,
  input  logic [BLK_W-1:0]               blk_i,
  input  logic [WAYS-1:0]                vld_i,
  input  logic [WAYS-1:0][BLK_W-1:0]     tag_i,
  output logic                           hit_o,
  output logic [WAYS-1:0]                vld_o,
  output logic [WAYS-1:0][BLK_W-1:0]     tag_o
);
  logic [WAYS-1:0] match;
  int              lim;
  logic            shift;

  always_comb begin
    for (int i = 0; i < WAYS; i++) match[i] = vld_i[i] && (tag_i[i] == blk_i);
    hit_o = |match;
    lim   = WAYS - 1;
    for (int i = WAYS - 1; i >= 0; i--) if (match[i]) lim = i;
    // FIFO hit keeps order; every other case pushes at head down to lim
    shift = !hit_o || (pol_i == POL_LRU);
    vld_o = vld_i;
    tag_o = tag_i;
    if (shift) begin
      vld_o[0] = 1'b1;
      tag_o[0] = blk_i;
      for (int i = 1; i < WAYS; i++) begin
        if (i <= lim) begin
          vld_o[i] = vld_i[i-1];
          tag_o[i] = tag_i[i-1];
        end
      end
    end
  end
endmodule

// File: rtl/tagdir_sat_cnt.sv
module tagdir_sat_cnt #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_o <= '0;
    else if (inc_i && ~&cnt_o)    cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/assoc_tag_dir.sv
module assoc_tag_dir
  import tagdir_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int SETS        = 16,
  parameter int BLOCK_BYTES = 32,
  parameter int WAYS        = 4,
  parameter int CNT_W       = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              policy_fifo_i,
  output logic              resp_valid_o,
  output logic              resp_hit_o,
  output logic [CNT_W-1:0]  hit_count_o,
  output logic [CNT_W-1:0]  miss_count_o
);
  localparam int OFF_W = $clog2(BLOCK_BYTES);
  localparam int IDX_W = $clog2(SETS);
  localparam int BLK_W = ADDR_W - OFF_W;

  logic [WAYS-1:0]            vld_q [SETS];
  logic [WAYS-1:0][BLK_W-1:0] tag_q [SETS];
  logic [IDX_W-1:0]           set_idx;
  logic [BLK_W-1:0]           blk;
  logic                       hit_now;
  logic [WAYS-1:0]            vld_nxt;
  logic [WAYS-1:0][BLK_W-1:0] tag_nxt;
  repl_pol_e                  pol_q;

  tagdir_split #(
    .ADDR_W(ADDR_W), .SETS(SETS), .BLOCK_BYTES(BLOCK_BYTES)
  ) i_split (
    .addr_i(req_addr_i), .set_o(set_idx), .blk_o(blk)
  );

  tagdir_order #(
    .WAYS(WAYS), .BLK_W(BLK_W)
  ) i_order (
    .pol_i(pol_q), .blk_i(blk),
    .vld_i(vld_q[set_idx]), .tag_i(tag_q[set_idx]),
    .hit_o(hit_now), .vld_o(vld_nxt), .tag_o(tag_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        tag_q[s] <= '0;
      end
    end else if (req_valid_i) begin
      vld_q[set_idx] <= vld_nxt;
      tag_q[set_idx] <= tag_nxt;
    end
  end

  // mode only moves while idle so an access never sees a half-switched set
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           pol_q <= POL_LRU;
    else if (!req_valid_i) pol_q <= repl_pol_e'(policy_fifo_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      resp_valid_o <= 1'b0;
      resp_hit_o   <= 1'b0;
    end else begin
      resp_valid_o <= req_valid_i;
      resp_hit_o   <= req_valid_i && hit_now;
    end
  end

  tagdir_sat_cnt #(.W(CNT_W)) i_hit_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .inc_i(req_valid_i && hit_now), .cnt_o(hit_count_o)
  );

  tagdir_sat_cnt #(.W(CNT_W)) i_miss_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .inc_i(req_valid_i && !hit_now), .cnt_o(miss_count_o)
  );
endmodule

// File: rtl/assoc_tag_dir_chk.sv
module assoc_tag_dir_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             resp_valid_o,
  input logic             resp_hit_o,
  input logic [CNT_W-1:0] hit_count_o,
  input logic [CNT_W-1:0] miss_count_o
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  a_r2_one_cycle_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o == $past(req_valid_i));

  a_r8_hit_increments: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_o && resp_hit_o && $past(hit_count_o) != CMAX)
      |-> hit_count_o == $past(hit_count_o) + 1'b1);

  a_r8_miss_increments: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_o && !resp_hit_o && $past(miss_count_o) != CMAX)
      |-> miss_count_o == $past(miss_count_o) + 1'b1);

  a_r8_idle_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !resp_valid_o |-> ($stable(hit_count_o) && $stable(miss_count_o)));

  a_r8_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(hit_count_o) == CMAX) |-> hit_count_o == CMAX);

  a_r8_other_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_o && resp_hit_o) |-> $stable(miss_count_o));
endmodule

bind assoc_tag_dir assoc_tag_dir_chk #(.CNT_W(CNT_W)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i),
  .resp_valid_o(resp_valid_o), .resp_hit_o(resp_hit_o),
  .hit_count_o(hit_count_o), .miss_count_o(miss_count_o)
);

// File: tb/test_assoc_tag_dir.sv
module test_assoc_tag_dir;
  localparam int CLK_PERIOD = 10;
  localparam int SETS       = 16;
  localparam int WAYS       = 4;
  localparam int DM_CW      = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vld = 1'b0;
  logic        pol = 1'b0;
  logic [31:0] addr = '0;
  logic        rv_a, rh_a, rv_d, rh_d;
  logic [31:0] hc_a, mc_a;
  logic [DM_CW-1:0] hc_d, mc_d;

  assoc_tag_dir #(.SETS(SETS), .WAYS(WAYS)) i_assoc_tag_dir (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(vld), .req_addr_i(addr),
    .policy_fifo_i(pol), .resp_valid_o(rv_a), .resp_hit_o(rh_a),
    .hit_count_o(hc_a), .miss_count_o(mc_a));

  assoc_tag_dir #(.SETS(SETS), .WAYS(1), .CNT_W(DM_CW)) i_assoc_tag_dir_dm (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(vld), .req_addr_i(addr),
    .policy_fifo_i(pol), .resp_valid_o(rv_d), .resp_hit_o(rh_d),
    .hit_count_o(hc_d), .miss_count_o(mc_d));

  always #(CLK_PERIOD/2) clk = ~clk;

  longint unsigned lst [2][SETS][$];
  int              ways_m [2] = '{WAYS, 1};
  longint unsigned hc [2], mc [2];
  longint unsigned cmax [2] = '{64'hFFFF_FFFF, 64'd7};
  bit              pol_m = 1'b0;
  bit              exp_v;
  bit              exp_h [2];
  int              n_chk = 0, n_fail = 0;
  string           cur_req = "R3";
  bit              done = 1'b0;

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit step(int k, int s, longint unsigned b, bit fifo);
    int pos = -1;
    foreach (lst[k][s][i]) if (pos < 0 && lst[k][s][i] == b) pos = i;
    if (pos >= 0) begin
      if (!fifo) begin
        lst[k][s].delete(pos);
        lst[k][s].push_front(b);
      end
      return 1'b1;
    end
    lst[k][s].push_front(b);
    if (lst[k][s].size() > ways_m[k]) void'(lst[k][s].pop_back());
    return 1'b0;
  endfunction

  function automatic logic [31:0] mk(int tag, int set, int off);
    return (32'(tag) << 9) | (32'(set) << 5) | 32'(off);
  endfunction

  task automatic cycle(bit v, logic [31:0] a, bit p);
    vld = v; addr = a; pol = p;
    if (v) begin
      for (int k = 0; k < 2; k++) begin
        exp_h[k] = step(k, int'((a >> 5) & 32'hF), longint'(a >> 5), pol_m);
        if (exp_h[k]) begin if (hc[k] < cmax[k]) hc[k]++; end
        else begin if (mc[k] < cmax[k]) mc[k]++; end
      end
    end else pol_m = p;
    exp_v = v;
    @(negedge clk);
    chk("R2", "valid", 64'(rv_a), 64'(exp_v));
    chk("R2", "valid dm", 64'(rv_d), 64'(exp_v));
    if (exp_v) begin
      chk(cur_req, "hit", 64'(rh_a), 64'(exp_h[0]));
      chk("R6", "hit dm", 64'(rh_d), 64'(exp_h[1]));
    end
    chk("R8", "hit count", 64'(hc_a), hc[0]);
    chk("R8", "miss count", 64'(mc_a), mc[0]);
    chk("R8", "hit count dm", 64'(hc_d), hc[1]);
    chk("R8", "miss count dm", 64'(mc_d), mc[1]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    hc = '{0, 0}; mc = '{0, 0};
    repeat (3) @(negedge clk);
    chk("R3", "valid in reset", 64'(rv_a), 0);
    chk("R3", "hits in reset", 64'(hc_a), 0);
    chk("R3", "misses in reset", 64'(mc_a), 0);
    chk("R3", "dm misses in reset", 64'(mc_d), 0);
    rst_n = 1'b1;
    cycle(0, 0, 0);
    cycle(1, mk(0, 0, 0), 0); // R3: zero address must miss, nothing valid

    cur_req = "R1";
    cycle(1, mk(1, 0, 0), 0);
    cycle(1, mk(1, 0, 31), 0);
    cycle(1, mk(2, 0, 4), 0);
    cycle(1, mk(1, 1, 0), 0);
    cycle(1, mk(1, 0, 8), 0);
    cycle(1, mk(257, 0, 0), 0);

    cur_req = "R4";
    for (int t = 1; t <= 4; t++) cycle(1, mk(t, 2, 0), 0);
    cycle(1, mk(1, 2, 0), 0);
    cycle(1, mk(5, 2, 0), 0);
    cycle(1, mk(1, 2, 0), 0);
    cycle(1, mk(2, 2, 0), 0);
    cycle(1, mk(3, 2, 0), 0);

    cur_req = "R7";
    cycle(1, mk(7, 3, 0), 0);
    cycle(1, mk(7, 3, 16), 0);
    cycle(1, mk(8, 3, 0), 0);
    cycle(1, mk(7, 3, 0), 0);

    cur_req = "R9";
    cycle(0, 0, 1);
    cur_req = "R5";
    for (int t = 1; t <= 4; t++) cycle(1, mk(t, 4, 0), 0); // R9: pol=0 ignored while busy
    cycle(1, mk(1, 4, 0), 0);
    cycle(1, mk(5, 4, 0), 0);
    cycle(1, mk(1, 4, 0), 0);
    cycle(1, mk(2, 4, 0), 0);
    cur_req = "R9";
    cycle(0, 0, 0);
    cycle(1, mk(3, 4, 0), 1);
    cycle(1, mk(9, 4, 0), 1);
    cycle(1, mk(3, 4, 0), 1);
    cycle(1, mk(5, 4, 0), 1);

    cur_req = "R6";
    for (int r = 0; r < 4; r++) begin
      cycle(1, mk(10, 6, 0), 0);
      cycle(1, mk(11, 6, 0), 0);
    end

    cur_req = "R4";
    for (int r = 0; r < 3000; r++)
      cycle(($urandom % 4) != 0, mk($urandom % 6, $urandom % 3, $urandom % 32), 1'($urandom % 2));
    cycle(0, 0, 0);

    chk("R8", "dm misses saturated", 64'(mc_d), 7);
    chk("R8", "dm hits saturated", 64'(hc_d), 7);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule